// File: doc/BRIEF.md
# Grouped Card Register Decoder with Broadcast Run Control

This block sits behind a small bus slave with a 16-bit address and 8-bit data on one acquisition card. Several cards share a crate. A common main address groups them, and a per-card sub-address picks out one card within the group. Both settings come from DIP switches wired so that a closed (ON) switch reads as logic 1 on the input pin but stands for an address bit of 0. The decoder therefore inverts the raw levels before comparing them with the bus address.

Only odd byte addresses are used. The low three address bits choose one of four registers:

| Low bits | Register | Access | Addressed by |
|---|---|---|---|
| 001 | Run start/stop | Write | Main address only (broadcast) |
| 011 | Control, with status readback | Read and write | Main and sub address |
| 101 | Station number | Write only | Main and sub address |
| 111 | Data size code | Write only | Main and sub address |

A write to the run register is accepted by every card in the group. Every card in the group can therefore be started or stopped with a single write. The other three registers respond only on the addressed card.

Every decoded access is answered with an acknowledge. The acknowledge and the read data are registered, so they appear in the cycle after the strobe.

Top module: `bus_reg_decoder`

## Requirements
- R1: After reset these outputs are 0: run_en, ctrl_reg, station_id, bus_ack and bus_rdata. size_code is 2, so data_bits is 12.
- R2: The main-address setting is the bitwise inverse of main_sw_raw. An access whose addr[15:8] differs from that setting is not acknowledged and changes no register.
- R3: A write with addr[0]=1, addr[2:1]=00 and a matching main address loads bus_wdata[0] into run_en, whatever addr[7:3] is. It is acknowledged.
- R4: The sub-address setting is the bitwise inverse of sub_sw_raw. Offsets 011, 101 and 111 are decoded only when addr[7:3] equals that setting. Otherwise the access is not acknowledged and changes nothing.
- R5: A write to offset 011 stores bus_wdata[6:0] in ctrl_reg and ignores bit 7. Bit 0 of ctrl_reg is the mode bit (0 = normal) and drives mode_alt. A read of offset 011 returns {run_en, ctrl_reg}.
- R6: A write to offset 101 stores all 8 data bits in station_id. A write to offset 111 stores bus_wdata[2:0] in size_code.
- R7: data_bits equals 10 + size_code for codes 0 to 6. Code 7 is reserved and gives 16.
- R8: An access with addr[0]=0 is ignored. It is not acknowledged and changes no register.
- R9: A decoded read of offset 001, 101 or 111 is acknowledged and returns 0. A read of offset 001 is decoded only when the sub-address matches.
- R10: bus_ack is high for exactly the one cycle after a decoded strobe. bus_rdata is 0 whenever bus_ack is low.
- R11: When bus_wr and bus_rd are high in the same cycle, the write is performed and a single acknowledge is given with bus_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_sw_raw | input | 8 | Raw main-address switch levels (1 = ON = address bit 0) |
| sub_sw_raw | input | 5 | Raw sub-address switch levels (1 = ON = address bit 0) |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ack | output | 1 | Acknowledge, one cycle after a decoded access |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| run_en | output | 1 | Collection run enable |
| ctrl_reg | output | 7 | Control register |
| mode_alt | output | 1 | Mode bit (0 = normal) |
| station_id | output | 8 | Station number |
| size_code | output | 3 | Data size code |
| data_bits | output | 5 | Decoded data width in bits |

## Verification
Two things can fall in the same cycle: the write path and the read path. They meet when bus_wr and bus_rd are raised together on one address, including offset 011, whose read would otherwise return the status byte. The bench provokes this with a directed case and with about one random access in ten. It judges each case by checking that:
- the write took effect,
- exactly one acknowledge followed,
- the read data was zero.

A second overlap also gets directed coverage: a broadcast run write that uses another card's sub-address. It must still change run_en here, while a control write with that same foreign sub-address must not.

// File: rtl/bus_reg_decoder.sv
module bus_reg_decoder #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MAIN_W    = 8,
  parameter int SUB_W     = 5,
  parameter int SIZE_W    = 3,
  parameter int BASE_BITS = 10,
  parameter logic [2:0] SIZE_RST = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAIN_W-1:0] main_sw_raw,
  input  logic [SUB_W-1:0]  sub_sw_raw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_en,
  output logic [DATA_W-2:0] ctrl_reg,
  output logic              mode_alt,
  output logic [DATA_W-1:0] station_id,
  output logic [SIZE_W-1:0] size_code,
  output logic [4:0]        data_bits
);
  localparam int SUB_LO  = ADDR_W - MAIN_W - SUB_W;
  localparam int MAIN_LO = ADDR_W - MAIN_W;
  localparam logic [SIZE_W-1:0] SIZE_MAX = '1;

  logic [MAIN_W-1:0] main_sel;
  logic [SUB_W-1:0]  sub_sel;
  logic [1:0]        ofs;
  logic main_hit, sub_hit, odd, strobe;
  logic card_sel, bcast_wr, decoded;
  logic wr_ctrl, wr_stn, wr_size, rd_stat;

  assign main_sel = ~main_sw_raw;
  assign sub_sel  = ~sub_sw_raw;
  assign main_hit = bus_addr[ADDR_W-1:MAIN_LO] == main_sel;
  assign sub_hit  = bus_addr[MAIN_LO-1:SUB_LO] == sub_sel;
  assign odd      = bus_addr[0];
  assign ofs      = bus_addr[2:1];
  assign strobe   = bus_wr | bus_rd;

  assign card_sel = main_hit & sub_hit & odd;
  assign bcast_wr = bus_wr & main_hit & odd & (ofs == 2'd0);
  assign decoded  = strobe & (card_sel | bcast_wr);

  assign wr_ctrl  = bus_wr & card_sel & (ofs == 2'd1);
  assign wr_stn   = bus_wr & card_sel & (ofs == 2'd2);
  assign wr_size  = bus_wr & card_sel & (ofs == 2'd3);
  assign rd_stat  = bus_rd & ~bus_wr & card_sel & (ofs == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en     <= 1'b0;
      ctrl_reg   <= '0;
      station_id <= '0;
      size_code  <= SIZE_RST;
      bus_ack    <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (bcast_wr) run_en     <= bus_wdata[0];
      if (wr_ctrl)  ctrl_reg   <= bus_wdata[DATA_W-2:0];
      if (wr_stn)   station_id <= bus_wdata;
      if (wr_size)  size_code  <= bus_wdata[SIZE_W-1:0];
      bus_ack   <= decoded;
      bus_rdata <= rd_stat ? {run_en, ctrl_reg} : '0;
    end
  end

  assign mode_alt  = ctrl_reg[0];
  assign data_bits = (size_code == SIZE_MAX) ? 5'(BASE_BITS + 6)
                                             : 5'(BASE_BITS) + 5'(size_code);
endmodule

// File: rtl/bus_reg_decoder_chk.sv
module bus_reg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  main_sw_raw,
  input logic [15:0] bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_ack,
  input logic [7:0]  bus_rdata,
  input logic        run_en,
  input logic [7:0]  station_id,
  input logic [4:0]  data_bits
);
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_wr | bus_rd)); // R10
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> bus_rdata == 8'h00); // R10
  AST_MAIN_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr | bus_rd) && bus_addr[15:8] != ~main_sw_raw) |=> !bus_ack); // R2
  AST_EVEN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr | bus_rd) && !bus_addr[0]) |=> !bus_ack); // R8
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(run_en)); // R3
  AST_STATION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(station_id)); // R6
  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    data_bits >= 5'd10 && data_bits <= 5'd16); // R7
endmodule

bind bus_reg_decoder bus_reg_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_sw_raw(main_sw_raw), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
  .run_en(run_en), .station_id(station_id), .data_bits(data_bits)
);

// File: tb/bus_reg_decoder_tb.sv
module bus_reg_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] main_sw_raw = 8'hF7;
  logic [4:0] sub_sw_raw = 5'h1D;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic bus_ack, run_en, mode_alt;
  logic [7:0] bus_rdata, station_id;
  logic [6:0] ctrl_reg;
  logic [2:0] size_code;
  logic [4:0] data_bits;

  int checks = 0, fails = 0;
  logic m_run; logic [6:0] m_ctrl; logic [7:0] m_stn; logic [2:0] m_size;

  always #10 clk = ~clk;

  bus_reg_decoder u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] c);
    return (c == 3'd7) ? 16 : 10 + int'(c);
  endfunction

  task automatic check_regs(input string req);
    chk(run_en == m_run, req, "run_en", run_en, m_run);
    chk(ctrl_reg == m_ctrl, req, "ctrl_reg", ctrl_reg, m_ctrl);
    chk(mode_alt == m_ctrl[0], req, "mode_alt", mode_alt, m_ctrl[0]);
    chk(station_id == m_stn, req, "station_id", station_id, m_stn);
    chk(size_code == m_size, req, "size_code", size_code, m_size);
    chk(int'(data_bits) == width_of(m_size), "R7", "data_bits", data_bits, width_of(m_size));
  endtask

  task automatic access(input logic [15:0] a, input logic [7:0] d, input bit w, input bit r, input string req);
    bit mh, sh, od, dec; logic [1:0] o; logic [7:0] exp_rd;
    @(negedge clk);
    chk(bus_ack == 1'b0, "R10", "ack idle before strobe", bus_ack, 0);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    mh = a[15:8] == ~main_sw_raw;
    sh = a[7:3] == ~sub_sw_raw;
    od = a[0]; o = a[2:1];
    dec = (w || r) && mh && od && (sh || (w && o == 2'd0));
    exp_rd = (r && !w && mh && sh && od && o == 2'd1) ? {m_run, m_ctrl} : 8'h00;
    if (w && mh && od && o == 2'd0) m_run = d[0];
    if (w && mh && sh && od) begin
      if (o == 2'd1) m_ctrl = d[6:0];
      if (o == 2'd2) m_stn = d;
      if (o == 2'd3) m_size = d[2:0];
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk(bus_ack == dec, req, "ack", bus_ack, dec);
    chk(bus_rdata == exp_rd, req, "rdata", bus_rdata, exp_rd);
    check_regs(req);
  endtask

  function automatic logic [15:0] mk(input bit mh, input bit sh, input logic [2:0] lo);
    logic [7:0] mp; logic [4:0] sp;
    mp = mh ? ~main_sw_raw : (~main_sw_raw ^ 8'($urandom_range(1, 255)));
    sp = sh ? ~sub_sw_raw : (~sub_sw_raw ^ 5'($urandom_range(1, 31)));
    return {mp, sp, lo};
  endfunction

  initial begin
    #(200000 * 20);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_run = 0; m_ctrl = 0; m_stn = 0; m_size = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_ack == 0, "R1", "reset ack", bus_ack, 0);
    chk(bus_rdata == 0, "R1", "reset rdata", bus_rdata, 0);
    check_regs("R1");
    chk(data_bits == 5'd12, "R1", "reset width", data_bits, 12);

    access(mk(1, 0, 3'b001), 8'h01, 1, 0, "R3 broadcast start foreign sub");
    access(mk(1, 0, 3'b011), 8'h55, 1, 0, "R4 ctrl write foreign sub");
    access(mk(0, 1, 3'b011), 8'h33, 1, 0, "R2 main miss");
    access(mk(1, 1, 3'b010), 8'h44, 1, 0, "R8 even address");
    access(mk(1, 1, 3'b011), 8'hFF, 1, 0, "R5 ctrl write bit7 ignored");
    access(mk(1, 1, 3'b011), 8'h00, 0, 1, "R5 status read");
    access(mk(1, 1, 3'b101), 8'hA5, 1, 0, "R6 station write");
    access(mk(1, 1, 3'b101), 8'h00, 0, 1, "R9 station read zero");
    access(mk(1, 1, 3'b001), 8'h00, 0, 1, "R9 run read zero");
    access(mk(1, 0, 3'b001), 8'h00, 0, 1, "R9 run read foreign sub");
    access(mk(1, 1, 3'b011), 8'h2A, 1, 1, "R11 write and read together");
    for (int c = 0; c < 8; c++) begin
      access(mk(1, 1, 3'b111), 8'(c) | 8'hF8, 1, 0, "R7 size sweep");
      access(mk(1, 1, 3'b111), 8'h00, 0, 1, "R9 size read zero");
    end
    access(mk(1, 0, 3'b001), 8'h00, 1, 0, "R3 broadcast stop");

    for (int n = 0; n < 600; n++) begin
      bit mh, sh, w, r; int k;
      if (n % 150 == 149) begin
        @(negedge clk);
        main_sw_raw = 8'($urandom); sub_sw_raw = 5'($urandom);
      end
      mh = $urandom_range(0, 9) < 8;
      sh = $urandom_range(0, 1) == 1;
      k = $urandom_range(0, 9);
      w = k < 5 || k == 9;
      r = k >= 5;
      access(mk(mh, sh, 3'($urandom)), 8'($urandom), w, r, "R2 R3 R4 R5 R6 R8 R9 R11 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule